// File: doc/BRIEF.md
# Fail-Stop Request Arbiter

This block merges the requests of K+1 redundant processing replicas into one logical requester that either behaves correctly or halts where everyone can see it. Each replica owns a request slot. The first request with an acceptable timestamp opens a collection round of a fixed number of cycles. Every further acceptable request that arrives inside that round fills the slot of the replica that sent it.

When the round closes, the arbiter checks three conditions: every slot is filled exactly once, the slots hold the same operation, and the block is not halted. If all three hold, the arbiter carries out that operation. An agreed write updates a small protected register store. An agreed read returns the stored word to every replica at once. In every other case the arbiter raises a halt flag. The flag stays raised until reset, and while it is raised no request is served.

The parameter K sets how many replica faults are tolerated. The block therefore has K+1 request ports. Clock alignment between the replicas is left to the system. The arbiter only compares each request's timestamp with a shared time reference.

Top module: `fail_stop_arbiter`

## Requirements
- R1: After reset the halt flag is 0, the write-done and read-valid outputs are 0, and every word of the register store reads as 0.
- R2: A round opens on the first clock edge that samples an acceptable request while the block is idle. Requests sampled on that edge and on the next WINDOW-1 edges are counted. The verdict appears on the outputs right after the edge that follows, which is edge WINDOW counted from the opening edge.
- R3: If all K+1 slots agree on a write (write bit 1, same address, same data), the store word at that address takes the data, and write-done is 1 for exactly one cycle.
- R4: If all K+1 slots agree on a read (write bit 0, same address, same data field), every bit of read-valid is 1 for one cycle, and every DW-bit lane of read data carries the stored word.
- R5: A request is acceptable only when (now_ts - req_ts) mod 2^TSW is at most TS_TOL. Any other request is discarded. It fills no slot and cannot open a round.
- R6: If any slot is still empty when the round closes, the halt flag is set and nothing is written or read.
- R7: If the filled slots differ in the write bit, the address or the data field, the halt flag is set and the store is not written.
- R8: A second request from a replica whose slot is already filled in the same round sets the halt flag at the close, even when every slot agrees.
- R9: A request sampled on the closing edge is dropped. It does not join the closing round and does not open a new one.
- R10: Once set, the halt flag stays set until reset. While it is set, write-done and read-valid stay 0 whatever is requested.
- R11: In any cycle at most one of these happens: write-done, read-valid, or the halt flag rising. Read-valid is either all zeros or all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vld | input | K+1 | Request strobe, one bit per replica |
| req_wr | input | K+1 | 1 = write, 0 = read, one bit per replica |
| req_addr | input | (K+1)*AW | Word address, replica i in bits [i*AW +: AW] |
| req_wdata | input | (K+1)*DW | Data field, replica i in bits [i*DW +: DW] |
| req_ts | input | (K+1)*TSW | Request timestamp, replica i in bits [i*TSW +: TSW] |
| now_ts | input | TSW | Shared time reference |
| wr_done | output | 1 | Agreed write carried out |
| rd_valid | output | K+1 | Agreed read answered, one bit per replica |
| rd_data | output | (K+1)*DW | Read word, copied to every lane |
| halted | output | 1 | Sticky fail-stop flag |

## Verification
The round's closing edge is also the last moment a late replica or a repeat request can arrive. Two things can therefore fall in one cycle: issuing a verdict on the stored slots, and sampling a fresh request. The bench provokes this by holding one replica back until the closing edge (R9). It also sends a replica's request twice inside a window whose slots otherwise agree (R8). A scoreboard expects exactly one halt event and no further verdict. Any verdict drawn from the late request, or any second round opened by it, shows up as an unexpected event.

// File: rtl/fsa_pkg.sv
package fsa_pkg;

   typedef enum logic [1:0] {
      VERD_NONE  = 2'd0,
      VERD_WRITE = 2'd1,
      VERD_READ  = 2'd2,
      VERD_HALT  = 2'd3
   } verdict_e;

endpackage

// File: rtl/fsa_ts_gate.sv
module fsa_ts_gate #(
   parameter int TSW      = 8,
   parameter int TS_TOL   = 4,
   parameter bit TS_CHECK = 1'b1
) (
   input  logic           vld,
   input  logic [TSW-1:0] ts,
   input  logic [TSW-1:0] now,
   output logic           ok
);

   generate
      if (TS_CHECK) begin : g_check
         logic [TSW-1:0] age;
         assign age = now - ts;
         assign ok  = vld && (age <= TSW'(TS_TOL));
      end else begin : g_pass
         logic [TSW-1:0] unused_ts;
         assign unused_ts = ts ^ now;
         assign ok = vld;
      end
   endgenerate

endmodule

// File: rtl/fsa_round_collect.sv
module fsa_round_collect #(
   parameter int N      = 3,
   parameter int AW     = 3,
   parameter int DW     = 8,
   parameter int WINDOW = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N-1:0]    take,
   input  logic [N-1:0]    in_wr,
   input  logic [N*AW-1:0] in_addr,
   input  logic [N*DW-1:0] in_wdata,
   output logic            close,
   output logic [N-1:0]    slot_full,
   output logic            slot_dup,
   output logic [N-1:0]    slot_wr,
   output logic [N*AW-1:0] slot_addr,
   output logic [N*DW-1:0] slot_wdata
);

   localparam int CW = (WINDOW > 1) ? $clog2(WINDOW) : 1;

   logic          collecting;
   logic [CW-1:0] cnt;
   logic          start;
   logic          open_edge;
   logic [N-1:0]  dup_q;

   assign start     = !collecting && (|take);
   assign close     = collecting && (cnt == '0);
   assign open_edge = start || (collecting && !close);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         collecting <= 1'b0;
         cnt        <= '0;
      end else if (start) begin
         collecting <= 1'b1;
         cnt        <= CW'(WINDOW - 1);
      end else if (close) begin
         collecting <= 1'b0;
      end else if (collecting) begin
         cnt <= cnt - 1'b1;
      end
   end

   generate
      for (genvar i = 0; i < N; i++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_full[i]             <= 1'b0;
               dup_q[i]                 <= 1'b0;
               slot_wr[i]               <= 1'b0;
               slot_addr[i*AW +: AW]    <= '0;
               slot_wdata[i*DW +: DW]   <= '0;
            end else if (close) begin
               slot_full[i] <= 1'b0;
               dup_q[i]     <= 1'b0;
            end else if (open_edge && take[i]) begin
               if (slot_full[i]) begin
                  dup_q[i] <= 1'b1;
               end else begin
                  slot_full[i]           <= 1'b1;
                  slot_wr[i]             <= in_wr[i];
                  slot_addr[i*AW +: AW]  <= in_addr[i*AW +: AW];
                  slot_wdata[i*DW +: DW] <= in_wdata[i*DW +: DW];
               end
            end
         end
      end
   endgenerate

   assign slot_dup = |dup_q;

endmodule

// File: rtl/fsa_agree.sv
module fsa_agree #(
   parameter int N  = 3,
   parameter int AW = 3,
   parameter int DW = 8
) (
   input  logic [N-1:0]    full,
   input  logic            dup,
   input  logic [N-1:0]    wr,
   input  logic [N*AW-1:0] addr,
   input  logic [N*DW-1:0] wdata,
   output logic            pass,
   output logic            op_wr,
   output logic [AW-1:0]   op_addr,
   output logic [DW-1:0]   op_wdata
);

   logic [N-1:0] same;

   generate
      for (genvar i = 0; i < N; i++) begin : g_cmp
         assign same[i] = (wr[i] == wr[0]) &&
                          (addr[i*AW +: AW] == addr[AW-1:0]) &&
                          (wdata[i*DW +: DW] == wdata[DW-1:0]);
      end
   endgenerate

   assign pass     = (&full) && (&same) && !dup;
   assign op_wr    = wr[0];
   assign op_addr  = addr[AW-1:0];
   assign op_wdata = wdata[DW-1:0];

endmodule

// File: rtl/fsa_store.sv
module fsa_store #(
   parameter int AW = 3,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[addr] <= wdata;
      end
   end

   assign rdata = mem[addr];

endmodule

// File: rtl/fail_stop_arbiter.sv
module fail_stop_arbiter #(
   parameter int K        = 2,
   parameter int AW       = 3,
   parameter int DW       = 8,
   parameter int TSW      = 8,
   parameter int TS_TOL   = 4,
   parameter int WINDOW   = 4,
   parameter bit TS_CHECK = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [K:0]          req_vld,
   input  logic [K:0]          req_wr,
   input  logic [(K+1)*AW-1:0] req_addr,
   input  logic [(K+1)*DW-1:0] req_wdata,
   input  logic [(K+1)*TSW-1:0] req_ts,
   input  logic [TSW-1:0]      now_ts,
   output logic                wr_done,
   output logic [K:0]          rd_valid,
   output logic [(K+1)*DW-1:0] rd_data,
   output logic                halted
);
   import fsa_pkg::*;

   localparam int NSRC = K + 1;

   generate
      if (K < 1) begin : g_bad_k
         $error("fail_stop_arbiter: K must be at least 1");
      end
      if (WINDOW < 1) begin : g_bad_window
         $error("fail_stop_arbiter: WINDOW must be at least 1");
      end
      if (TS_TOL < 0 || TS_TOL >= (1 << (TSW - 1))) begin : g_bad_tol
         $error("fail_stop_arbiter: TS_TOL out of range for TSW");
      end
   endgenerate

   logic [NSRC-1:0]    ts_ok;
   logic [NSRC-1:0]    take;
   logic               close;
   logic [NSRC-1:0]    s_full;
   logic               s_dup;
   logic [NSRC-1:0]    s_wr;
   logic [NSRC*AW-1:0] s_addr;
   logic [NSRC*DW-1:0] s_wdata;
   logic               pass;
   logic               op_wr;
   logic [AW-1:0]      op_addr;
   logic [DW-1:0]      op_wdata;
   logic [DW-1:0]      st_rdata;
   logic               st_we;
   verdict_e           verdict;
   logic               halt_q;

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_gate
         fsa_ts_gate #(
            .TSW(TSW), .TS_TOL(TS_TOL), .TS_CHECK(TS_CHECK)
         ) u_gate (
            .vld (req_vld[i]),
            .ts  (req_ts[i*TSW +: TSW]),
            .now (now_ts),
            .ok  (ts_ok[i])
         );
      end
   endgenerate

   assign take = halt_q ? '0 : ts_ok;

   fsa_round_collect #(
      .N(NSRC), .AW(AW), .DW(DW), .WINDOW(WINDOW)
   ) u_collect (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (take),
      .in_wr      (req_wr),
      .in_addr    (req_addr),
      .in_wdata   (req_wdata),
      .close      (close),
      .slot_full  (s_full),
      .slot_dup   (s_dup),
      .slot_wr    (s_wr),
      .slot_addr  (s_addr),
      .slot_wdata (s_wdata)
   );

   fsa_agree #(
      .N(NSRC), .AW(AW), .DW(DW)
   ) u_agree (
      .full     (s_full),
      .dup      (s_dup),
      .wr       (s_wr),
      .addr     (s_addr),
      .wdata    (s_wdata),
      .pass     (pass),
      .op_wr    (op_wr),
      .op_addr  (op_addr),
      .op_wdata (op_wdata)
   );

   always_comb begin
      verdict = VERD_NONE;
      if (close) begin
         if (pass && !halt_q) verdict = op_wr ? VERD_WRITE : VERD_READ;
         else                 verdict = VERD_HALT;
      end
   end

   assign st_we = (verdict == VERD_WRITE);

   fsa_store #(
      .AW(AW), .DW(DW)
   ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (st_we),
      .addr  (op_addr),
      .wdata (op_wdata),
      .rdata (st_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_done  <= 1'b0;
         rd_valid <= '0;
         rd_data  <= '0;
         halt_q   <= 1'b0;
      end else begin
         wr_done  <= (verdict == VERD_WRITE);
         rd_valid <= (verdict == VERD_READ) ? '1 : '0;
         if (verdict == VERD_READ) rd_data <= {NSRC{st_rdata}};
         if (verdict == VERD_HALT) halt_q <= 1'b1;
      end
   end

   assign halted = halt_q;

endmodule

// File: rtl/fsa_checks.sv
module fsa_checks #(
   parameter int N  = 3,
   parameter int DW = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr_done,
   input logic [N-1:0]    rd_valid,
   input logic [N*DW-1:0] rd_data,
   input logic            halted
);

   // R10: halt flag is sticky
   a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   // R10: no service while halted
   a_r10_no_service: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (!wr_done && rd_valid == '0));

   // R11: read-valid all or nothing
   a_r11_rd_all_or_none: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid == '0) || (rd_valid == '1));

   // R11: write and read never together
   a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_done && (|rd_valid)));

   // R11: halting edge carries no service
   a_r11_halt_alone: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halted) |-> (!wr_done && rd_valid == '0));

   // R3: write-done lasts one cycle
   a_r3_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |=> !wr_done);

   // R4: every lane carries the same word
   a_r4_lanes_equal: assert property (@(posedge clk) disable iff (!rst_n)
      (|rd_valid) |-> (rd_data == {N{rd_data[DW-1:0]}}));

endmodule

bind fail_stop_arbiter fsa_checks #(.N(NSRC), .DW(DW)) u_checks (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_done  (wr_done),
   .rd_valid (rd_valid),
   .rd_data  (rd_data),
   .halted   (halted)
);

// File: tb/fail_stop_arbiter_bench.sv
module fail_stop_arbiter_bench;

   localparam int PERIOD = 10;
   localparam int K      = 2;
   localparam int N      = K + 1;
   localparam int AW     = 3;
   localparam int DW     = 8;
   localparam int TSW    = 8;
   localparam int TOL    = 4;
   localparam int WIN    = 4;

   localparam int EV_WR   = 1;
   localparam int EV_RD   = 2;
   localparam int EV_HALT = 3;

   typedef struct {
      int            kind;
      logic [DW-1:0] val;
      string         req;
   } exp_t;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [N-1:0]       req_vld = '0;
   logic [N-1:0]       req_wr = '0;
   logic [N*AW-1:0]    req_addr = '0;
   logic [N*DW-1:0]    req_wdata = '0;
   logic [N*TSW-1:0]   req_ts = '0;
   logic [TSW-1:0]     now_ts = 8'd100;
   logic               wr_done;
   logic [N-1:0]       rd_valid;
   logic [N*DW-1:0]    rd_data;
   logic               halted;

   int vectors = 0;
   int miscompares = 0;
   exp_t q[$];
   logic prev_halt = 1'b0;

   logic            wr_a   [N];
   logic [AW-1:0]   addr_a [N];
   logic [DW-1:0]   data_a [N];
   logic [TSW-1:0]  ts_a   [N];
   int              off_a  [N];
   int              dup_src;
   int              dup_off;

   always #(PERIOD/2) clk = ~clk;

   fail_stop_arbiter #(
      .K(K), .AW(AW), .DW(DW), .TSW(TSW), .TS_TOL(TOL), .WINDOW(WIN)
   ) u_fail_stop_arbiter (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ts(req_ts),
      .now_ts(now_ts), .wr_done(wr_done), .rd_valid(rd_valid),
      .rd_data(rd_data), .halted(halted)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // monitor: pops the scoreboard whenever the design produces an event
   always @(negedge clk) begin
      if (rst_n) begin
         int nev;
         int kind;
         nev  = 0;
         kind = 0;
         if (wr_done)             begin nev++; kind = EV_WR;   end
         if (|rd_valid)           begin nev++; kind = EV_RD;   end
         if (halted && !prev_halt) begin nev++; kind = EV_HALT; end
         if (nev > 1) check(1'b0, "R11", "simultaneous events", nev, 1);
         if (nev == 1) begin
            if (q.size() == 0) begin
               check(1'b0, "R9", "unexpected event kind", kind, 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               check(kind == e.kind, e.req, "event kind", kind, e.kind);
               if (kind == EV_RD && e.kind == EV_RD) begin
                  check(rd_valid == '1, "R11", "read-valid lanes",
                        int'(rd_valid), int'({N{1'b1}}));
                  for (int i = 0; i < N; i++)
                     check(rd_data[i*DW +: DW] == e.val, e.req, "read lane",
                           int'(rd_data[i*DW +: DW]), int'(e.val));
               end
            end
         end
         prev_halt = halted;
      end else begin
         prev_halt = 1'b0;
      end
   end

   task automatic expect_ev(input int kind, input logic [DW-1:0] val,
                            input string req);
      exp_t e;
      e.kind = kind;
      e.val  = val;
      e.req  = req;
      q.push_back(e);
   endtask

   task automatic do_reset();
      req_vld = '0;
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic setup(input logic wr, input logic [AW-1:0] addr,
                        input logic [DW-1:0] data);
      for (int i = 0; i < N; i++) begin
         wr_a[i]   = wr;
         addr_a[i] = addr;
         data_a[i] = data;
         ts_a[i]   = now_ts - 8'd1;
         off_a[i]  = 0;
      end
      dup_src = -1;
      dup_off = -1;
   endtask

   // driver: presents one round, then confirms every expected event was seen
   task automatic play(input string req);
      for (int i = 0; i < N; i++) begin
         req_wr[i]               = wr_a[i];
         req_addr[i*AW +: AW]    = addr_a[i];
         req_wdata[i*DW +: DW]   = data_a[i];
         req_ts[i*TSW +: TSW]    = ts_a[i];
      end
      for (int c = 0; c <= WIN; c++) begin
         for (int i = 0; i < N; i++)
            req_vld[i] = (off_a[i] == c) || (dup_src == i && dup_off == c);
         @(negedge clk);
      end
      req_vld = '0;
      repeat (4) @(negedge clk);
      check(q.size() == 0, req, "expected events outstanding", q.size(), 0);
      q.delete();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "watchdog", "run did not finish", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check(halted == 1'b0, "R1", "halt after reset", int'(halted), 0);
      check(wr_done == 1'b0, "R1", "write-done after reset", int'(wr_done), 0);
      check(rd_valid == '0, "R1", "read-valid after reset", int'(rd_valid), 0);

      // R1: store reads zero after reset
      setup(1'b0, 3'd5, 8'h00);
      expect_ev(EV_RD, 8'h00, "R1");
      play("R1");

      // R3: agreed write, all replicas in first cycle
      setup(1'b1, 3'd3, 8'h5A);
      expect_ev(EV_WR, 8'h00, "R3");
      play("R3");

      // R4 / R2: agreed read with staggered replicas, last on cycle WIN-1
      setup(1'b0, 3'd3, 8'h00);
      off_a[1] = 1;
      off_a[2] = WIN - 1;
      expect_ev(EV_RD, 8'h5A, "R2");
      play("R4");

      // R5: timestamp exactly at tolerance is accepted
      setup(1'b1, 3'd6, 8'hC3);
      ts_a[2] = now_ts - 8'(TOL);
      off_a[0] = 2;
      expect_ev(EV_WR, 8'h00, "R5");
      play("R5");
      setup(1'b0, 3'd6, 8'h11);
      expect_ev(EV_RD, 8'hC3, "R3");
      play("R3");

      // R5: all stale or future stamps open no round
      setup(1'b1, 3'd6, 8'hEE);
      ts_a[0] = now_ts - 8'(TOL + 1);
      ts_a[1] = now_ts - 8'd20;
      ts_a[2] = now_ts + 8'd2;
      play("R5");
      check(halted == 1'b0, "R5", "halt after stale round", int'(halted), 0);
      setup(1'b0, 3'd6, 8'h00);
      expect_ev(EV_RD, 8'hC3, "R5");
      play("R5");

      // R5: one stale replica leaves its slot empty, so the arbiter halts
      setup(1'b1, 3'd1, 8'h77);
      ts_a[1] = now_ts - 8'(TOL + 3);
      expect_ev(EV_HALT, 8'h00, "R5");
      play("R5");

      // R10: halted block serves nothing
      setup(1'b0, 3'd6, 8'h00);
      play("R10");
      setup(1'b1, 3'd6, 8'h99);
      play("R10");
      check(halted == 1'b1, "R10", "halt sticky", int'(halted), 1);

      // R6: missing replica
      do_reset();
      check(halted == 1'b0, "R10", "halt cleared by reset", int'(halted), 0);
      setup(1'b1, 3'd2, 8'h42);
      off_a[2] = -1;
      expect_ev(EV_HALT, 8'h00, "R6");
      play("R6");

      // R7: data mismatch
      do_reset();
      setup(1'b1, 3'd2, 8'h42);
      data_a[2] = 8'h43;
      expect_ev(EV_HALT, 8'h00, "R7");
      play("R7");

      // R7: write-bit mismatch, store must stay unwritten
      do_reset();
      setup(1'b1, 3'd4, 8'h24);
      wr_a[0] = 1'b0;
      expect_ev(EV_HALT, 8'h00, "R7");
      play("R7");

      // R7: address mismatch on a write after a good write; word unchanged
      do_reset();
      setup(1'b1, 3'd7, 8'hA1);
      expect_ev(EV_WR, 8'h00, "R3");
      play("R3");
      setup(1'b1, 3'd7, 8'hB2);
      addr_a[1] = 3'd0;
      data_a[1] = 8'hB2;
      expect_ev(EV_HALT, 8'h00, "R7");
      play("R7");

      // R8: repeated request from one replica, all slots agreeing
      do_reset();
      setup(1'b1, 3'd1, 8'h3C);
      dup_src = 1;
      dup_off = 2;
      expect_ev(EV_HALT, 8'h00, "R8");
      play("R8");

      // R9: replica arriving on the closing edge is dropped, no new round
      do_reset();
      setup(1'b0, 3'd0, 8'h00);
      off_a[2] = WIN;
      expect_ev(EV_HALT, 8'h00, "R9");
      play("R9");

      // R9: after reset a full round still works (store was cleared)
      do_reset();
      setup(1'b0, 3'd7, 8'h00);
      expect_ev(EV_RD, 8'h00, "R1");
      play("R1");

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule